// File: doc/BRIEF.md
# Programmable Slow-Idle Clock Enable Generator

This block produces the clock enables for a processor core and for three peripheral clock domains: the serial clock, the clock output and the timer tick. In normal operation every enable is high on every cycle. An idle command arrives together with a flag that says whether it carries a divisor. Without a divisor the block enters a standard idle. The core enable drops, the peripheral enables keep full rate, and a wake-up interrupt is answered in the same cycle.

With a divisor, the block enters a divided idle. A 2-bit select picks a ratio of 16, 32, 64 or 128. The core enable and all three peripheral enables then pulse together for one cycle in every n cycles, so the whole clock tree runs at the same reduced rate. An interrupt that is both unmasked and globally enabled is remembered. The block leaves idle on the next common pulse, so every domain returns to full rate on the same boundary. This bounds the wake latency by n cycles.

DMA cycle-steal requests are granted in every mode. The grant follows one cycle after the request, with fixed priority to the lowest index. A global interrupt enable sits inside the block. It is set at reset and is changed by set and clear commands.

Top module: `slow_idle_clkgen`

## Requirements
- R1: After reset the block is in normal operation: all four enables are high, `idle_active`, `wake` and `dma_gnt` are low, and the global interrupt enable is set.
- R2: In normal operation `core_en`, `sclk_en`, `clkout_en` and `tmr_en` are high on every cycle and `idle_active` is low.
- R3: An `idle_cmd` with `idle_has_div`=0 enters standard idle from the next cycle. In standard idle `core_en` is low, the three peripheral enables stay high and `idle_active` is high.
- R4: In standard idle, `wake` is high in any cycle where an interrupt is pending and enabled and the global enable is set. Normal operation starts in the following cycle.
- R5: An `idle_cmd` with `idle_has_div`=1 enters divided idle with n = 16 << `idle_div_sel` (00→16, 01→32, 10→64, 11→128). The division counter restarts on entry. All four enables are high together for exactly one cycle in every n cycles, first in the n-th idle cycle, and low otherwise.
- R6: In divided idle, a wake interrupt causes `wake` on the next common enable pulse, at most n cycles later. Normal operation starts in the following cycle.
- R7: An interrupt whose `irq_en` bit is 0, or any interrupt while the global enable is clear, does not end idle. `gie_clr` clears the global enable and `gie_set` sets it. When both arrive in the same cycle, clear wins.
- R8: `dma_gnt` is one-hot or zero. In the cycle after a request it grants the lowest-indexed requester, in every mode.
- R9: An `idle_cmd` that arrives while idle has no effect on mode or divisor.
- R10: A wake interrupt that arrives and goes away between two pulses of divided idle is remembered. It still wakes the block on the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_cmd | input | 1 | One-cycle idle command strobe |
| idle_has_div | input | 1 | 1: command carries a divisor; 0: standard idle |
| idle_div_sel | input | SEL_W | Divisor select, n = 2^(DIV_LOG_MIN + sel) |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_en | input | IRQ_W | Per-line enable, 1 = unmasked |
| gie_set | input | 1 | Set the global interrupt enable |
| gie_clr | input | 1 | Clear the global interrupt enable (wins over set) |
| dma_req | input | DMA_W | Cycle-steal requests |
| dma_gnt | output | DMA_W | Registered one-hot grant |
| core_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | Serial clock enable |
| clkout_en | output | 1 | Clock output enable |
| tmr_en | output | 1 | Timer tick enable |
| idle_active | output | 1 | High while in either idle mode |
| wake | output | 1 | High in the cycle idle ends |

## Verification
Two functions can fall in the same cycle: the wake decision of divided idle and the common enable pulse, while a DMA grant is also issued. The bench places an interrupt exactly on a pulse cycle and also well before one, and keeps DMA requests active across the whole idle window. A cycle-accurate reference model pushes the expected enables, `wake` and `dma_gnt` for every cycle. The monitor then checks that the wake lands on the pulse, that all enables rise together, and that grants continue without a gap.

// File: rtl/slic_pkg.sv
package slic_pkg;

   typedef enum logic [1:0] {
      MODE_RUN = 2'd0,
      MODE_STD = 2'd1,
      MODE_DIV = 2'd2
   } slic_mode_e;

   function automatic int unsigned slic_cnt_width(input int unsigned log_min,
                                                  input int unsigned sel_w);
      return log_min + (1 << sel_w) - 1;
   endfunction

endpackage

// File: rtl/slic_divider.sv
module slic_divider
   import slic_pkg::*;
#(
   parameter int unsigned DIV_LOG_MIN = 4,
   parameter int unsigned SEL_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned CNT_W  = slic_cnt_width(DIV_LOG_MIN, SEL_W);
   localparam int unsigned N_SEL  = 1 << SEL_W;

   logic [CNT_W-1:0] term_tbl [N_SEL];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;

   generate
      for (genvar g = 0; g < N_SEL; g++) begin : g_term
         localparam int unsigned LOGN = DIV_LOG_MIN + g;
         assign term_tbl[g] = CNT_W'((64'd1 << LOGN) - 64'd1);
      end
   endgenerate

   assign term = term_tbl[sel];
   assign tick = run && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= tick ? '0 : cnt_q + 1'b1;
      end
   end

   // R5: counter never passes the selected terminal count
   a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= term));

   // R5: a restart always puts the counter back to zero
   a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/slic_wake.sv
module slic_wake
   import slic_pkg::*;
#(
   parameter int unsigned IRQ_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  slic_mode_e       mode,
   input  logic             tick,
   input  logic [IRQ_W-1:0] irq_pend,
   input  logic [IRQ_W-1:0] irq_en,
   input  logic             gie_set,
   input  logic             gie_clr,
   output logic             wake
);
   logic gie_q;
   logic held_q;
   logic hit;

   assign hit = gie_q && (|(irq_pend & irq_en));

   always_comb begin
      unique case (mode)
         MODE_STD: wake = hit;
         MODE_DIV: wake = tick && (held_q || hit);
         default:  wake = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= 1'b1;
      end else if (gie_clr) begin
         gie_q <= 1'b0;
      end else if (gie_set) begin
         gie_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
      end else if (mode != MODE_DIV || wake) begin
         held_q <= 1'b0;
      end else if (hit) begin
         held_q <= 1'b1;
      end
   end

   // R7: clear wins over set in the same cycle
   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_set && gie_clr) |=> !gie_q);

   // R7: with the global enable off and nothing held, idle is not left
   a_r7_no_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie_q && !held_q) |-> !wake);

   // R10: a remembered request persists until the wake pulse
   a_r10_held_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && mode == MODE_DIV && !wake) |=> held_q);

endmodule

// File: rtl/slic_dma_arb.sv
module slic_dma_arb #(
   parameter int unsigned DMA_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DMA_W-1:0] req,
   output logic [DMA_W-1:0] gnt
);
   logic [DMA_W-1:0] pick;
   logic [DMA_W:0]   seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < DMA_W; i++) begin : g_pri
         assign pick[i]   = req[i] && !seen[i];
         assign seen[i+1] = seen[i] || req[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt <= '0;
      else        gnt <= pick;
   end

   // R8: at most one grant
   a_r8_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R8: a grant only goes to a line that requested one cycle earlier
   a_r8_gnt_from_req: assert property (@(posedge clk) disable iff (!rst_n)
      |req |=> ((gnt & $past(req)) == gnt) && (gnt != '0));

endmodule

// File: rtl/slow_idle_clkgen.sv
module slow_idle_clkgen
   import slic_pkg::*;
#(
   parameter int unsigned DIV_LOG_MIN = 4,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned IRQ_W       = 4,
   parameter int unsigned DMA_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle_cmd,
   input  logic             idle_has_div,
   input  logic [SEL_W-1:0] idle_div_sel,
   input  logic [IRQ_W-1:0] irq_pend,
   input  logic [IRQ_W-1:0] irq_en,
   input  logic             gie_set,
   input  logic             gie_clr,
   input  logic [DMA_W-1:0] dma_req,
   output logic [DMA_W-1:0] dma_gnt,
   output logic             core_en,
   output logic             sclk_en,
   output logic             clkout_en,
   output logic             tmr_en,
   output logic             idle_active,
   output logic             wake
);
   generate
      if (DIV_LOG_MIN < 1 || DIV_LOG_MIN > 20) begin : g_bad_log
         $error("slow_idle_clkgen: DIV_LOG_MIN out of range");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("slow_idle_clkgen: SEL_W out of range");
      end
      if (IRQ_W < 1) begin : g_bad_irq
         $error("slow_idle_clkgen: IRQ_W must be positive");
      end
      if (DMA_W < 1) begin : g_bad_dma
         $error("slow_idle_clkgen: DMA_W must be positive");
      end
   endgenerate

   slic_mode_e       mode_q;
   logic [SEL_W-1:0] sel_q;
   logic             accept;
   logic             tick;
   logic             in_run;
   logic             in_std;
   logic             in_div;

   assign in_run = (mode_q == MODE_RUN);
   assign in_std = (mode_q == MODE_STD);
   assign in_div = (mode_q == MODE_DIV);
   assign accept = in_run && idle_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RUN;
         sel_q  <= '0;
      end else if (accept) begin
         mode_q <= idle_has_div ? MODE_DIV : MODE_STD;
         sel_q  <= idle_div_sel;
      end else if (wake) begin
         mode_q <= MODE_RUN;
      end
   end

   slic_divider #(
      .DIV_LOG_MIN (DIV_LOG_MIN),
      .SEL_W       (SEL_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (in_div),
      .sel     (sel_q),
      .tick    (tick)
   );

   slic_wake #(
      .IRQ_W (IRQ_W)
   ) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_q),
      .tick     (tick),
      .irq_pend (irq_pend),
      .irq_en   (irq_en),
      .gie_set  (gie_set),
      .gie_clr  (gie_clr),
      .wake     (wake)
   );

   slic_dma_arb #(
      .DMA_W (DMA_W)
   ) u_dma (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (dma_req),
      .gnt   (dma_gnt)
   );

   assign core_en     = in_run || (in_div && tick);
   assign sclk_en     = in_run || in_std || (in_div && tick);
   assign clkout_en   = sclk_en;
   assign tmr_en      = sclk_en;
   assign idle_active = !in_run;

   // R2: normal operation runs every enable at full rate
   a_r2_run_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
      in_run |-> (core_en && sclk_en && clkout_en && tmr_en && !idle_active));

   // R3: standard idle gates only the core
   a_r3_std_core_only: assert property (@(posedge clk) disable iff (!rst_n)
      in_std |-> (!core_en && sclk_en && tmr_en));

   // R4: a wake from standard idle resumes on the next cycle
   a_r4_std_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (in_std && wake) |=> (mode_q == MODE_RUN));

   // R6: divided wake only lands on a common enable pulse
   a_r6_wake_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (in_div && wake) |-> (core_en && sclk_en && clkout_en && tmr_en));

   // R9: an idle command during idle leaves mode and divisor alone
   a_r9_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_run && !wake) |=> ($stable(mode_q) && $stable(sel_q)));

endmodule

// File: tb/slow_idle_clkgen_tb.sv
module slow_idle_clkgen_tb;
   localparam int DMA_W = 3;
   localparam int IRQ_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idle_cmd = 0, idle_has_div = 0, gie_set = 0, gie_clr = 0;
   logic [1:0] idle_div_sel = '0;
   logic [IRQ_W-1:0] irq_pend = '0, irq_en = '0;
   logic [DMA_W-1:0] dma_req = '0, dma_gnt;
   logic core_en, sclk_en, clkout_en, tmr_en, idle_active, wake;

   always #10 clk = ~clk;

   slow_idle_clkgen u_dut (
      .clk(clk), .rst_n(rst_n), .idle_cmd(idle_cmd), .idle_has_div(idle_has_div),
      .idle_div_sel(idle_div_sel), .irq_pend(irq_pend), .irq_en(irq_en),
      .gie_set(gie_set), .gie_clr(gie_clr), .dma_req(dma_req), .dma_gnt(dma_gnt),
      .core_en(core_en), .sclk_en(sclk_en), .clkout_en(clkout_en), .tmr_en(tmr_en),
      .idle_active(idle_active), .wake(wake)
   );

   typedef struct packed {
      logic core, sclk, clko, tmr, idle, wk;
      logic [DMA_W-1:0] gnt;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string tag = "R1";

   // reference model state
   int        m_mode = 0;
   int        m_cnt = 0;
   int        m_sel = 0;
   bit        m_held = 0;
   bit        m_gie = 1;
   logic [DMA_W-1:0] m_gnt = '0;

   task automatic chk(string req, string name, logic [7:0] act, logic [7:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: %s got %0h expected %0h", req, name, act, expv);
      end
   endtask

   // driver: model one cycle from the current inputs, push, advance
   task automatic step();
      exp_t e;
      bit hit, tk;
      int n;
      logic [DMA_W-1:0] nx;
      hit = m_gie && (|(irq_pend & irq_en));
      n = 16 << m_sel;
      tk = (m_mode == 2) && (m_cnt == n - 1);
      e.gnt = m_gnt;
      case (m_mode)
         0: begin e.core = 1; e.sclk = 1; e.clko = 1; e.tmr = 1; e.idle = 0; e.wk = 0; end
         1: begin e.core = 0; e.sclk = 1; e.clko = 1; e.tmr = 1; e.idle = 1; e.wk = hit; end
         default: begin
            e.core = tk; e.sclk = tk; e.clko = tk; e.tmr = tk; e.idle = 1;
            e.wk = tk && (m_held || hit);
         end
      endcase
      exp_q.push_back(e);
      tag_q.push_back(tag);
      nx = '0;
      for (int i = DMA_W - 1; i >= 0; i--) if (dma_req[i]) nx = '0 | (1 << i);
      m_gnt = nx;
      case (m_mode)
         0: if (idle_cmd) begin
               m_mode = idle_has_div ? 2 : 1; m_sel = idle_div_sel; m_cnt = 0; m_held = 0;
            end
         1: if (e.wk) m_mode = 0;
         default: begin
            if (e.wk) begin m_mode = 0; m_held = 0; end
            else begin
               if (hit) m_held = 1;
               m_cnt = tk ? 0 : m_cnt + 1;
            end
         end
      endcase
      if (gie_clr) m_gie = 0;
      else if (gie_set) m_gie = 1;
      @(negedge clk);
   endtask

   task automatic steps(int k);
      for (int i = 0; i < k; i++) step();
   endtask

   // monitor: pops expected items and compares away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #8;
         if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "core_en",     {7'd0, core_en},     {7'd0, e.core});
            chk(t, "sclk_en",     {7'd0, sclk_en},     {7'd0, e.sclk});
            chk(t, "clkout_en",   {7'd0, clkout_en},   {7'd0, e.clko});
            chk(t, "tmr_en",      {7'd0, tmr_en},      {7'd0, e.tmr});
            chk(t, "idle_active", {7'd0, idle_active}, {7'd0, e.idle});
            chk(t, "wake",        {7'd0, wake},        {7'd0, e.wk});
            chk((t == "R8") ? "R8" : t, "dma_gnt", 8'(dma_gnt), 8'(e.gnt));
         end
      end
   end

   task automatic go_idle(bit div, logic [1:0] sel);
      idle_cmd = 1; idle_has_div = div; idle_div_sel = sel;
      step();
      idle_cmd = 0; idle_has_div = 0;
   endtask

   initial begin
      irq_en = 4'b0011;
      repeat (3) @(negedge clk);
      // R1: reset state while held in reset
      chk("R1", "core_en reset", {7'd0, core_en}, 8'd1);
      chk("R1", "tmr_en reset", {7'd0, tmr_en}, 8'd1);
      chk("R1", "idle_active reset", {7'd0, idle_active}, 8'd0);
      chk("R1", "dma_gnt reset", 8'(dma_gnt), 8'd0);
      rst_n = 1;
      @(negedge clk);

      // R2 and R8: full rate with varied request patterns
      tag = "R2"; steps(3);
      tag = "R8";
      dma_req = 3'b110; step();
      dma_req = 3'b111; step();
      dma_req = 3'b100; step();
      dma_req = 3'b000; step();

      // R3, R7, R9, R4: standard idle
      tag = "R3"; go_idle(0, 2'b00); steps(3);
      tag = "R7"; irq_pend = 4'b1100; steps(3);
      tag = "R9"; idle_cmd = 1; idle_has_div = 1; step(); idle_cmd = 0; idle_has_div = 0; steps(2);
      tag = "R4"; irq_pend = 4'b0001; step(); irq_pend = '0; steps(3);

      // R5, R6, R8: divided idle for every select, wake on the pulse cycle
      for (int s = 0; s < 4; s++) begin
         tag = "R5"; dma_req = 3'b011;
         go_idle(1, 2'(s));
         steps((16 << s) - 2);
         tag = "R6"; irq_pend = 4'b0010; step(); irq_pend = '0;
         dma_req = 3'b000; steps(3);
      end

      // R10: short pulse early in the window is remembered; R9 during divided idle
      tag = "R10"; go_idle(1, 2'b01); steps(4);
      irq_pend = 4'b0001; step(); irq_pend = '0;
      tag = "R9"; idle_cmd = 1; idle_has_div = 0; idle_div_sel = 2'b11; step(); idle_cmd = 0;
      tag = "R10"; steps(32);

      // R7: global enable cleared, then set/clear together, then set
      tag = "R7"; gie_clr = 1; step(); gie_clr = 0;
      go_idle(1, 2'b00);
      irq_pend = 4'b0011; steps(40);
      gie_set = 1; gie_clr = 1; step(); gie_set = 0; gie_clr = 0;
      steps(20);
      gie_set = 1; step(); gie_set = 0;
      tag = "R6"; steps(20);
      irq_pend = '0;
      tag = "R2"; steps(4);

      @(negedge clk);
      #9;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule